// File: doc/BRIEF.md
# Multi-Decade BCD Capture Counter

This block is a synchronous decimal event counter with a set of holding registers. The count pulses come in on two inputs whose logical OR forms the counting signal. This lets an external prescaler drive either input, or lets a single source drive one input while the other is tied low. Each falling edge of the combined signal adds one to a chain of BCD decades. The chain rolls over to all zeros after the all-nines state.

A load strobe, active low, copies a stored image into a bank of digit registers. The image holds the internal decades together with two further BCD digits supplied from outside, typically the low digits of a fast prescaler. A sticky overflow flag is copied into its own output register by the same strobe. The overflow flag records the first falling edge on a dedicated input. The most significant bit of each of the top three digits is brought out so that one of them can be wired back to that input.

Every input is sampled into the system clock domain. Edges are found by comparing each sampled value with the one taken a cycle earlier. Reset is asynchronous on assertion and synchronous on release. Reset clears the decades, the overflow flag and the holding registers.

Top module: `bcd_capture_counter`

## Requirements
- R1: While reset is low and after it is released, every stored digit, the overflow output and the three MSB taps read zero until counting or loading changes them.
- R2: A falling edge of (count A OR count B) advances the count by exactly one. This holds whether A alone, B alone, or overlapping pulses on both inputs produce the edge.
- R3: The count carries in decimal: each internal decade stays in the range 0 to 9, and a decade advances when all lower decades pass from 9 to 0.
- R4: After the all-nines state, the next count edge returns every internal decade to 0.
- R5: Count edges that occur while reset is low are ignored, so the count is 0 once reset is released.
- R6: The overflow flag sets on a falling edge of the overflow-source input and stays set through further activity until reset.
- R7: While load is low, the digit outputs follow the stored image one sample behind. Digit k sits at bits [4k+3:4k]. Digits 0 and 1 come from the external input: bits [3:0] give digit 0 and bits [7:4] give digit 1. Digits 2 and up come from the internal decades, least significant first.
- R8: While load is high, the digit outputs and the overflow output hold their values, even as counting and external digits change.
- R9: The overflow output takes the value of the overflow flag whenever load is low.
- R10: Each MSB tap j always equals bit 3 of internal decade (NUM_DEC-3+j).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cnt_a_i | input | 1 | Count pulse input A |
| cnt_b_i | input | 1 | Count pulse input B |
| load_n_i | input | 1 | Active-low load strobe for the digit and overflow registers |
| ovf_src_i | input | 1 | Overflow source; a falling edge sets the flag |
| ext_digits_i | input | 4*NUM_EXT | External BCD digits, digit 0 in bits [3:0] |
| digits_o | output | 4*(NUM_DEC+NUM_EXT) | Held BCD digits, digit 0 least significant |
| ovf_o | output | 1 | Held overflow flag |
| msb_o | output | MSB_TAPS | Bit 3 of the top three internal decades, lowest first |

## Verification
The bench uses a three-decade build. It counts through more than one full cycle of 0 to 999, and checks the held digits, the external digits and the MSB taps after every single edge. The count edges rotate among input A, input B and overlapping pulses on both. A design that counted the overlap twice, or missed one input, would drift from the expected value. A carry that skipped a decade, or a rollover that stuck at 9 or went through hex A, would fail at the first boundary it reaches.

Edges sent during reset must leave zero behind. The held values must not move while load is high, and the overflow output must stay set after repeated source edges. A design that let data through while loading was off, or that cleared the overflow flag on its own, would be caught.

// File: rtl/bcd_cap_pkg.sv
package bcd_cap_pkg;

  localparam int unsigned BCD_W = 4;

  typedef logic [BCD_W-1:0] bcd_t;

  localparam bcd_t BCD_TOP = bcd_t'(9);

  // successor of one decimal digit, wrapping 9 -> 0
  function automatic bcd_t bcd_step(input bcd_t d);
    bcd_t r;
    if (d >= BCD_TOP) r = '0;
    else              r = d + bcd_t'(1);
    return r;
  endfunction

endpackage

// File: rtl/bcd_cap_sync.sv
// Multi-stage level synchroniser into the system clock domain.
module bcd_cap_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic level_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/bcd_cap_fall.sv
// Falling-edge finder on an already synchronised level.
module bcd_cap_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fall_o
);

  logic prev_q;
  logic prev_d;

  always_comb prev_d = level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign fall_o = prev_q & ~level_i;

  // one falling transition yields a single-cycle event (R2)
  p_single_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/bcd_cap_decade.sv
// One BCD decade with ripple-free carry enable.
module bcd_cap_decade
  import bcd_cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  output bcd_t value_o,
  output logic carry_o
);

  bcd_t val_q;
  bcd_t val_d;

  always_comb begin
    val_d = val_q;
    if (inc_i) val_d = bcd_step(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign carry_o = inc_i & (val_q == BCD_TOP);
  assign value_o = val_q;

  p_digit_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    val_q <= BCD_TOP);

  p_digit_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && val_q == BCD_TOP) |=> (val_q == '0));

  p_digit_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(val_q));

endmodule

// File: rtl/bcd_cap_latch.sv
// Holding registers for the digit image and the overflow flag.
module bcd_cap_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             ovf_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             ovf_o
);

  logic [WIDTH-1:0] hold_q, hold_d;
  logic             ovf_q,  ovf_d;

  always_comb begin
    hold_d = hold_q;
    ovf_d  = ovf_q;
    if (load_en_i) begin
      hold_d = din_i;
      ovf_d  = ovf_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      ovf_q  <= ovf_d;
    end
  end

  assign dout_o = hold_q;
  assign ovf_o  = ovf_q;

  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en_i |=> ($stable(hold_q) && $stable(ovf_q)));

  p_hold_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |=> (hold_q == $past(din_i)));

  p_ovf_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_i |=> (ovf_q == $past(ovf_i)));

endmodule

// File: rtl/bcd_capture_counter.sv
module bcd_capture_counter
  import bcd_cap_pkg::*;
#(
  parameter int unsigned NUM_DEC     = 6,
  parameter int unsigned NUM_EXT     = 2,
  parameter int unsigned MSB_TAPS    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cnt_a_i,
  input  logic                                cnt_b_i,
  input  logic                                load_n_i,
  input  logic                                ovf_src_i,
  input  logic [NUM_EXT*BCD_W-1:0]            ext_digits_i,
  output logic [(NUM_DEC+NUM_EXT)*BCD_W-1:0]  digits_o,
  output logic                                ovf_o,
  output logic [MSB_TAPS-1:0]                 msb_o
);

  localparam int unsigned NUM_DIG = NUM_DEC + NUM_EXT;
  localparam int unsigned IMG_W   = NUM_DIG * BCD_W;
  localparam int unsigned EXT_W   = NUM_EXT * BCD_W;
  localparam int unsigned TAP_LO  = NUM_DEC - MSB_TAPS;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // input conditioning
  logic cnt_raw;
  logic cnt_lvl, cnt_fall;
  logic ovf_lvl, ovf_fall;
  logic load_lvl_n;

  assign cnt_raw = cnt_a_i | cnt_b_i;

  bcd_cap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cnt (
    .clk(clk), .rst_n(rst_sync_n), .din_i(cnt_raw), .level_o(cnt_lvl));

  bcd_cap_fall u_fall_cnt (
    .clk(clk), .rst_n(rst_sync_n), .level_i(cnt_lvl), .fall_o(cnt_fall));

  bcd_cap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ovf (
    .clk(clk), .rst_n(rst_sync_n), .din_i(ovf_src_i), .level_o(ovf_lvl));

  bcd_cap_fall u_fall_ovf (
    .clk(clk), .rst_n(rst_sync_n), .level_i(ovf_lvl), .fall_o(ovf_fall));

  bcd_cap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
    .clk(clk), .rst_n(rst_sync_n), .din_i(load_n_i), .level_o(load_lvl_n));

  // decade chain
  logic [NUM_DEC:0]         inc;
  bcd_t [NUM_DEC-1:0]       dec_val;
  logic [NUM_DEC*BCD_W-1:0] dec_flat;

  assign inc[0] = cnt_fall;

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_decade
    bcd_cap_decade u_dec (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .inc_i  (inc[g]),
      .value_o(dec_val[g]),
      .carry_o(inc[g+1])
    );
    assign dec_flat[g*BCD_W +: BCD_W] = dec_val[g];
  end

  for (genvar t = 0; t < MSB_TAPS; t++) begin : g_tap
    assign msb_o[t] = dec_val[TAP_LO+t][BCD_W-1];
  end

  // sticky overflow flag
  logic ovf_ff_q, ovf_ff_d;

  always_comb begin
    ovf_ff_d = ovf_ff_q;
    if (ovf_fall) ovf_ff_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovf_ff_q <= 1'b0;
    else             ovf_ff_q <= ovf_ff_d;
  end

  // holding registers
  logic [IMG_W-1:0] image;
  logic [EXT_W-1:0] ext_unused_guard;

  assign ext_unused_guard = ext_digits_i;
  assign image = {dec_flat, ext_unused_guard};

  bcd_cap_latch #(.WIDTH(IMG_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en_i(~load_lvl_n),
    .din_i    (image),
    .ovf_i    (ovf_ff_q),
    .dout_o   (digits_o),
    .ovf_o    (ovf_o)
  );

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf_ff_q |=> ovf_ff_q);

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf_fall |=> ovf_ff_q);

  p_count_idle_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cnt_fall |=> $stable(dec_flat));

endmodule

// File: tb/bcd_capture_counter_tb.sv
module bcd_capture_counter_tb;

  localparam int NDEC = 3;
  localparam int NEXT = 2;
  localparam int DW   = (NDEC + NEXT) * 4;
  localparam int EW   = NEXT * 4;
  localparam int MOD  = 1000;

  logic          clk = 1'b0;
  logic          rst_n, cnt_a, cnt_b, load_n, ovf_src;
  logic [EW-1:0] ext;
  logic [DW-1:0] digits;
  logic          ovf;
  logic [2:0]    msb;

  int n_chk  = 0;
  int n_fail = 0;
  int count  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  bcd_capture_counter #(.NUM_DEC(NDEC), .NUM_EXT(NEXT), .MSB_TAPS(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .load_n_i(load_n), .ovf_src_i(ovf_src), .ext_digits_i(ext),
    .digits_o(digits), .ovf_o(ovf), .msb_o(msb));

  function automatic logic [DW-1:0] expect_img(int n, logic [EW-1:0] e);
    logic [DW-1:0] r;
    int v;
    v = n % MOD;
    r[EW-1:0] = e;
    for (int i = 0; i < NDEC; i++) begin
      r[EW+4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // mode 0: A only, 1: B only, 2: overlapping A and B
  task automatic pulse(int mode);
    case (mode)
      0: begin cnt_a = 1; cyc(3); cnt_a = 0; end
      1: begin cnt_b = 1; cyc(3); cnt_b = 0; end
      default: begin
        cnt_a = 1; cyc(2); cnt_b = 1; cyc(1); cnt_a = 0; cyc(2); cnt_b = 0;
      end
    endcase
    cyc(6);
  endtask

  task automatic ovf_pulse();
    ovf_src = 1; cyc(3); ovf_src = 0; cyc(6);
  endtask

  initial begin : watchdog
    cyc(150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [DW-1:0] snap, e;
    rst_n = 0; cnt_a = 0; cnt_b = 0; load_n = 1; ovf_src = 0; ext = '0;
    cyc(3);
    check(digits == '0, "R1 digits in reset", 64'(digits), 0);
    check(ovf == 1'b0,  "R1 ovf in reset", 64'(ovf), 0);
    check(msb == 3'b0,  "R1 msb in reset", 64'(msb), 0);
    // R5: edges during reset
    for (int i = 0; i < 4; i++) pulse(i % 3);
    rst_n = 1; cyc(4);
    load_n = 0; cyc(6);
    check(digits == '0, "R5 count after reset edges", 64'(digits), 0);
    check(ovf == 1'b0,  "R1 ovf after release", 64'(ovf), 0);

    // sweep beyond one full wrap with load held low
    for (int n = 1; n <= MOD + 5; n++) begin
      ext = {4'(n % 10), 4'((n * 7 + 3) % 10)};
      pulse(n % 3);
      count = n;
      e = expect_img(n, ext);
      if (n % MOD == 0)
        check(digits[DW-1:EW] == e[DW-1:EW], "R4 wrap", 64'(digits), 64'(e));
      else if (n % 3 == 2)
        check(digits[DW-1:EW] == e[DW-1:EW], "R2 overlap edge", 64'(digits), 64'(e));
      else
        check(digits[DW-1:EW] == e[DW-1:EW], "R3 decimal count", 64'(digits), 64'(e));
      check(digits[EW-1:0] == ext, "R7 external digits", 64'(digits[EW-1:0]), 64'(ext));
      check(msb == {e[DW-1], e[DW-5], e[DW-9]}, "R10 msb taps", 64'(msb),
            64'({e[DW-1], e[DW-5], e[DW-9]}));
    end

    // R8: hold while load high
    load_n = 1; cyc(4);
    snap = digits;
    for (int i = 0; i < 5; i++) pulse(i % 3);
    count += 5;
    ext = 8'h91;
    cyc(3);
    check(digits == snap, "R8 held digits", 64'(digits), 64'(snap));
    ovf_pulse();
    check(ovf == 1'b0, "R8 ovf held while load high", 64'(ovf), 0);
    load_n = 0; cyc(5);
    e = expect_img(count, ext);
    check(digits == e, "R7 reload after hold", 64'(digits), 64'(e));
    check(ovf == 1'b1, "R9 ovf copied on load", 64'(ovf), 1);
    // R6: sticky through more activity
    ovf_pulse(); ovf_pulse();
    check(ovf == 1'b1, "R6 ovf sticky", 64'(ovf), 1);
    // reset clears everything
    rst_n = 0; cyc(2);
    check(ovf == 1'b0, "R6 ovf cleared by reset", 64'(ovf), 0);
    check(digits == '0, "R1 digits cleared by reset", 64'(digits), 0);
    rst_n = 1; cyc(8);
    check(ovf == 1'b0, "R6 ovf stays clear", 64'(ovf), 0);
    check(digits[DW-1:EW] == '0, "R1 count zero after reset", 64'(digits), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule